// File: doc/BRIEF.md
# Initiator Address Decoder with Decode-Error Trapping

This block sits at the entry of one bus initiator into a shared memory interconnect. It compares each request address against a set of address windows, each a base and a mask fixed at build time. A request that falls inside a window is steered to exactly one target port. One instance is built per initiator, so a system with five initiators uses five copies.

An address that matches no window is never passed on. The block accepts it itself and answers the initiator with an error response that ends the transaction and carries the transaction ID. It also records the event in a sticky flag and a captured address, which a clear pulse erases. This trapping runs from reset and has no control that turns it off. While an error response waits for the initiator to take it, the block accepts no further requests.

Top module: `init_addr_decode`

## Requirements
- R1: A valid request that matches no window is accepted in the same cycle (`req_ready_o` high when no error response is pending), drives no bit of `tgt_valid_o`, and `err_rsp_valid_o` goes high on the next clock edge.
- R2: Trapping is active from the first request after reset, and no input disables it. Every accepted unmapped request sets `err_flag_o` on the following edge.
- R3: A request that matches a window drives exactly one bit of `tgt_valid_o`. `req_ready_o` equals the `tgt_ready_i` bit of that port. `tgt_addr_o` and `tgt_id_o` carry the request address and ID unchanged, and no error response follows.
- R4: Window i matches when `(addr & WIN_MASK[i]) == WIN_BASE[i]`. A match on window i selects port i, which is bit i of `tgt_valid_o`. By default, window 0 covers 0x0000_0000 to 0x000F_FFFF, window 1 covers 0x0800_0000 to 0x0807_FFFF, window 2 covers 0x0800_0000 to 0x08FF_FFFF, and window 3 covers 0xF000_0000 to 0xF0FF_FFFF.
- R5: When several windows match, the lowest-index window wins. By default 0x0800_1000 goes to port 1 and 0x0808_0000 goes to port 2.
- R6: The error response holds the ID of the request that caused it, and `err_rsp_valid_o` and `err_rsp_id_o` stay stable until a cycle in which `err_rsp_ready_i` is high.
- R7: `err_flag_o` and `err_addr_o` keep the first offending address until an `err_clr_i` pulse. A later miss does not overwrite them. A clear with no miss in the same cycle returns both to zero.
- R8: While `err_rsp_valid_o` is high, `req_ready_o` is low and `tgt_valid_o` is zero, whatever the request address.
- R9: An address that is not word-aligned but lies inside a window decodes normally, for example 0x0800_0002 to port 1.
- R10: If a clear pulse and an accepted miss fall in the same cycle, the flag stays set and `err_addr_o` takes the new address.
- R11: After reset, `tgt_valid_o`, `err_rsp_valid_o`, `err_rsp_id_o`, `err_flag_o` and `err_addr_o` are zero, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid from the initiator |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_addr_i | input | ADDR_W | Request address |
| req_id_i | input | ID_W | Request transaction ID |
| tgt_valid_o | output | N_WIN | One-hot request valid per target port |
| tgt_ready_i | input | N_WIN | Ready from each target port |
| tgt_addr_o | output | ADDR_W | Address passed to the targets |
| tgt_id_o | output | ID_W | ID passed to the targets |
| err_rsp_valid_o | output | 1 | Local error response valid |
| err_rsp_ready_i | input | 1 | Initiator takes the error response |
| err_rsp_id_o | output | ID_W | ID carried by the error response |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the sticky record |
| err_flag_o | output | 1 | Sticky decode-error flag |
| err_addr_o | output | ADDR_W | Captured first offending address |

## Verification
The sticky record can be cleared and set in the same cycle. This happens when a clear pulse arrives on the same edge that accepts a fresh unmapped request. The bench provokes it by leaving an earlier miss recorded, then driving `err_clr_i` together with a new unmapped address. It expects the flag to stay set and the captured address to change to the new one, not to zero and not to the old value. A neighbouring case checks the response path: a request held during a pending response must not be forwarded, even in the cycle the response is taken.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    // Upper bound on windows supported by one decoder instance
    localparam int MAX_WIN = 8;

    // State of the local error-response channel
    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_HOLD = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/win_match.sv
// Parallel base/mask compare, one comparator per window
module win_match #(
    parameter int ADDR_W = 32,
    parameter int N_WIN  = 4,
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_BASE = '0,
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_WIN-1:0]  hit_o
);

    for (genvar gi = 0; gi < N_WIN; gi++) begin : g_cmp
        assign hit_o[gi] = ((addr_i & WIN_MASK[gi]) == WIN_BASE[gi]);
    end

endmodule

// File: rtl/low_prio_pick.sv
// Keeps only the lowest-index set bit of the hit vector
module low_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit_i,
    output logic [N-1:0] sel_o
);

    logic [N-1:0] shadow;

    assign shadow[0] = 1'b0;
    for (genvar gi = 1; gi < N; gi++) begin : g_shadow
        assign shadow[gi] = shadow[gi-1] | hit_i[gi-1];
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_sel
        assign sel_o[gi] = hit_i[gi] & ~shadow[gi];
    end

endmodule

// File: rtl/err_trap.sv
// Local error response plus sticky record of the first unmapped address
module err_trap
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_take_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    input  logic [ID_W-1:0]   miss_id_i,
    input  logic              rsp_ready_i,
    input  logic              clr_i,
    output logic              rsp_valid_o,
    output logic [ID_W-1:0]   rsp_id_o,
    output logic              busy_o,
    output logic              flag_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        rsp_state_e        st;
        logic [ID_W-1:0]   id;
        logic              flag;
        logic [ADDR_W-1:0] addr;
    } trap_s;

    trap_s trap_d, trap_q;

    always_comb begin
        trap_d = trap_q;

        // response channel
        case (trap_q.st)
            RSP_IDLE: begin
                if (miss_take_i) begin
                    trap_d.st = RSP_HOLD;
                    trap_d.id = miss_id_i;
                end
            end
            RSP_HOLD: begin
                if (rsp_ready_i) begin
                    trap_d.st = RSP_IDLE;
                    trap_d.id = '0;
                end
            end
            default: trap_d.st = RSP_IDLE;
        endcase

        // sticky record: a new miss beats a clear in the same cycle
        if (miss_take_i) begin
            trap_d.flag = 1'b1;
            if (clr_i || !trap_q.flag) begin
                trap_d.addr = miss_addr_i;
            end
        end else if (clr_i) begin
            trap_d.flag = 1'b0;
            trap_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_q <= '{st: RSP_IDLE, id: '0, flag: 1'b0, addr: '0};
        end else begin
            trap_q <= trap_d;
        end
    end

    assign rsp_valid_o = (trap_q.st == RSP_HOLD);
    assign busy_o      = (trap_q.st == RSP_HOLD);
    assign rsp_id_o    = trap_q.id;
    assign flag_o      = trap_q.flag;
    assign addr_o      = trap_q.addr;

endmodule

// File: rtl/init_addr_decode.sv
module init_addr_decode
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int N_WIN  = 4,
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_BASE = {
        32'hF000_0000, 32'h0800_0000, 32'h0800_0000, 32'h0000_0000},
    parameter logic [N_WIN-1:0][ADDR_W-1:0] WIN_MASK = {
        32'hFF00_0000, 32'hFF00_0000, 32'hFFF8_0000, 32'hFFF0_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ID_W-1:0]   req_id_i,
    output logic [N_WIN-1:0]  tgt_valid_o,
    input  logic [N_WIN-1:0]  tgt_ready_i,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [ID_W-1:0]   tgt_id_o,
    output logic              err_rsp_valid_o,
    input  logic              err_rsp_ready_i,
    output logic [ID_W-1:0]   err_rsp_id_o,
    input  logic              err_clr_i,
    output logic              err_flag_o,
    output logic [ADDR_W-1:0] err_addr_o
);

    localparam int WIN_LIMIT = MAX_WIN;

    logic [N_WIN-1:0] win_hit;
    logic [N_WIN-1:0] win_sel;
    logic             any_hit;
    logic             busy;
    logic             offer;
    logic             miss_take;

    if (N_WIN > WIN_LIMIT || N_WIN < 1) begin : g_bad_cfg
        initial $error("init_addr_decode: N_WIN out of range");
    end

    win_match #(
        .ADDR_W   (ADDR_W),
        .N_WIN    (N_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_MASK (WIN_MASK)
    ) u_match (
        .addr_i (req_addr_i),
        .hit_o  (win_hit)
    );

    low_prio_pick #(
        .N (N_WIN)
    ) u_pick (
        .hit_i (win_hit),
        .sel_o (win_sel)
    );

    assign any_hit   = |win_hit;
    assign offer     = req_valid_i && !busy;
    assign miss_take = offer && !any_hit;

    always_comb begin
        tgt_valid_o = offer ? win_sel : '0;
        if (busy) begin
            req_ready_o = 1'b0;
        end else if (any_hit) begin
            req_ready_o = |(win_sel & tgt_ready_i);
        end else begin
            req_ready_o = 1'b1;
        end
    end

    assign tgt_addr_o = req_addr_i;
    assign tgt_id_o   = req_id_i;

    err_trap #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W)
    ) u_trap (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_take_i (miss_take),
        .miss_addr_i (req_addr_i),
        .miss_id_i   (req_id_i),
        .rsp_ready_i (err_rsp_ready_i),
        .clr_i       (err_clr_i),
        .rsp_valid_o (err_rsp_valid_o),
        .rsp_id_o    (err_rsp_id_o),
        .busy_o      (busy),
        .flag_o      (err_flag_o),
        .addr_o      (err_addr_o)
    );

endmodule

// File: rtl/init_addr_decode_chk.sv
module init_addr_decode_chk #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int N_WIN  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [ID_W-1:0]   req_id_i,
    input logic [N_WIN-1:0]  tgt_valid_o,
    input logic              err_rsp_valid_o,
    input logic              err_rsp_ready_i,
    input logic [ID_W-1:0]   err_rsp_id_o,
    input logic              err_clr_i,
    input logic              err_flag_o
);

    logic miss_acc;
    logic fwd_acc;

    assign miss_acc = req_valid_i && req_ready_o && (tgt_valid_o == '0);
    assign fwd_acc  = req_valid_i && req_ready_o && (tgt_valid_o != '0);

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_valid_o)); // R3

    AST_MISS_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |=> err_rsp_valid_o); // R1

    AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |=> err_flag_o); // R2

    AST_RSP_ID: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |=> (err_rsp_id_o == $past(req_id_i))); // R6

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rsp_valid_o && !err_rsp_ready_i) |=> (err_rsp_valid_o && $stable(err_rsp_id_o))); // R6

    AST_BLOCK_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        err_rsp_valid_o |-> (!req_ready_o && (tgt_valid_o == '0))); // R8

    AST_FWD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_acc |=> !err_rsp_valid_o); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !err_clr_i) |=> err_flag_o); // R7

endmodule

bind init_addr_decode init_addr_decode_chk #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .N_WIN  (N_WIN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_id_i        (req_id_i),
    .tgt_valid_o     (tgt_valid_o),
    .err_rsp_valid_o (err_rsp_valid_o),
    .err_rsp_ready_i (err_rsp_ready_i),
    .err_rsp_id_o    (err_rsp_id_o),
    .err_clr_i       (err_clr_i),
    .err_flag_o      (err_flag_o)
);

// File: tb/init_addr_decode_tb.sv
module init_addr_decode_tb;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;
    localparam int N_WIN  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_ready_o;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [ID_W-1:0]   req_id_i = '0;
    logic [N_WIN-1:0]  tgt_valid_o;
    logic [N_WIN-1:0]  tgt_ready_i = '1;
    logic [ADDR_W-1:0] tgt_addr_o;
    logic [ID_W-1:0]   tgt_id_o;
    logic              err_rsp_valid_o;
    logic              err_rsp_ready_i = 1'b0;
    logic [ID_W-1:0]   err_rsp_id_o;
    logic              err_clr_i = 1'b0;
    logic              err_flag_o;
    logic [ADDR_W-1:0] err_addr_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;  // 250 MHz

    init_addr_decode u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid_i),
        .req_ready_o     (req_ready_o),
        .req_addr_i      (req_addr_i),
        .req_id_i        (req_id_i),
        .tgt_valid_o     (tgt_valid_o),
        .tgt_ready_i     (tgt_ready_i),
        .tgt_addr_o      (tgt_addr_o),
        .tgt_id_o        (tgt_id_o),
        .err_rsp_valid_o (err_rsp_valid_o),
        .err_rsp_ready_i (err_rsp_ready_i),
        .err_rsp_id_o    (err_rsp_id_o),
        .err_clr_i       (err_clr_i),
        .err_flag_o      (err_flag_o),
        .err_addr_o      (err_addr_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid_i     = 1'b0;
        err_clr_i       = 1'b0;
        err_rsp_ready_i = 1'b0;
        tgt_ready_i     = '1;
    endtask

    task automatic t_reset();
        #1;
        chk("R11 tgt_valid", 64'(tgt_valid_o), 0);
        chk("R11 err_rsp_valid", 64'(err_rsp_valid_o), 0);
        chk("R11 err_rsp_id", 64'(err_rsp_id_o), 0);
        chk("R11 err_flag", 64'(err_flag_o), 0);
        chk("R11 err_addr", 64'(err_addr_o), 0);
        chk("R11 req_ready", 64'(req_ready_o), 1);
    endtask

    // forwarded request to one port; tag names the requirement under test
    task automatic t_hit(input string tag, input logic [31:0] a, input logic [3:0] id, input int port);
        req_valid_i = 1'b1; req_addr_i = a; req_id_i = id;
        #1;
        chk({tag, " tgt_valid"}, 64'(tgt_valid_o), 64'(1 << port));
        chk({tag, " req_ready"}, 64'(req_ready_o), 1);
        chk({tag, " tgt_addr"}, 64'(tgt_addr_o), 64'(a));
        chk({tag, " tgt_id"}, 64'(tgt_id_o), 64'(id));
        step();
        req_valid_i = 1'b0;
        chk({tag, " no err rsp"}, 64'(err_rsp_valid_o), 0);
    endtask

    task automatic t_stall();
        tgt_ready_i = 4'b1101;
        req_valid_i = 1'b1; req_addr_i = 32'h0800_0040; req_id_i = 4'h3;
        #1;
        chk("R3 ready follows port1 low", 64'(req_ready_o), 0);
        chk("R3 valid on port1 while stalled", 64'(tgt_valid_o), 64'h2);
        tgt_ready_i = 4'b0010;
        #1;
        chk("R3 ready follows port1 high", 64'(req_ready_o), 1);
        step();
        idle_inputs();
    endtask

    // unmapped request with a held response
    task automatic t_miss(input logic [31:0] a, input logic [3:0] id, input logic [31:0] exp_cap);
        req_valid_i = 1'b1; req_addr_i = a; req_id_i = id; err_rsp_ready_i = 1'b0;
        #1;
        chk("R1 miss accepted", 64'(req_ready_o), 1);
        chk("R1 miss not forwarded", 64'(tgt_valid_o), 0);
        step();
        chk("R1 err response next cycle", 64'(err_rsp_valid_o), 1);
        chk("R6 err response id", 64'(err_rsp_id_o), 64'(id));
        chk("R2 flag set", 64'(err_flag_o), 1);
        chk("R7 captured addr", 64'(err_addr_o), 64'(exp_cap));
        req_addr_i = 32'h0000_0100; req_id_i = 4'hE;
        #1;
        chk("R8 ready low while pending", 64'(req_ready_o), 0);
        chk("R8 no forward while pending", 64'(tgt_valid_o), 0);
        step();
        chk("R6 response held", 64'(err_rsp_valid_o), 1);
        chk("R6 id held", 64'(err_rsp_id_o), 64'(id));
        err_rsp_ready_i = 1'b1;
        #1;
        chk("R8 ready low in take cycle", 64'(req_ready_o), 0);
        chk("R8 no forward in take cycle", 64'(tgt_valid_o), 0);
        req_valid_i = 1'b0;
        step();
        chk("R6 response released", 64'(err_rsp_valid_o), 0);
        idle_inputs();
    endtask

    task automatic t_clear();
        err_clr_i = 1'b1;
        step();
        err_clr_i = 1'b0;
        chk("R7 clear drops flag", 64'(err_flag_o), 0);
        chk("R7 clear zeroes addr", 64'(err_addr_o), 0);
    endtask

    task automatic t_collision();
        req_valid_i = 1'b1; req_addr_i = 32'h4000_0008; req_id_i = 4'h9;
        err_clr_i = 1'b1; err_rsp_ready_i = 1'b0;
        step();
        err_clr_i = 1'b0; req_valid_i = 1'b0;
        chk("R10 flag survives clear", 64'(err_flag_o), 1);
        chk("R10 new addr captured", 64'(err_addr_o), 64'h4000_0008);
        chk("R10 response id", 64'(err_rsp_id_o), 64'h9);
        err_rsp_ready_i = 1'b1;
        step();
        idle_inputs();
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        idle_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_hit("R4 window0", 32'h0000_1234, 4'h1, 0);
        t_hit("R4 window0 top edge", 32'h000F_FFFC, 4'h2, 0);
        t_hit("R4 window3", 32'hF012_0000, 4'h4, 3);
        t_hit("R5 overlap low wins", 32'h0800_1000, 4'h5, 1);
        t_hit("R5 overlap outside win1", 32'h0808_0000, 4'h6, 2);
        t_hit("R9 unaligned", 32'h0800_0002, 4'h7, 1);
        t_hit("R9 unaligned odd", 32'h000F_FFFF, 4'h8, 0);
        t_stall();
        // first miss: just past window 0 (R2 trapping with no setup)
        t_miss(32'h0010_0000, 4'hA, 32'h0010_0000);
        // second miss: record keeps the first address
        t_miss(32'h2000_0001, 4'hB, 32'h0010_0000);
        t_clear();
        t_miss(32'h0900_0000, 4'hC, 32'h0900_0000);
        t_collision();
        t_clear();
        t_hit("R3 forward after errors", 32'hF0FF_FFF0, 4'hD, 3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule